// File: doc/BRIEF.md
# Instruction Immediate Extension Unit

This combinational unit turns a 32-bit instruction word into a 64-bit constant for the datapath. A format code says which kind of instruction is present. From that code the unit knows which bit range of the word holds the constant and whether to widen it as an unsigned or a two's-complement value. Each supported format has its own field extractor. One 64-bit multiplexer, steered by the format code, picks the final result.

There are four base formats: immediate arithmetic, data transfer, unconditional branch and compare-and-branch. Immediate arithmetic is the only one that is zero-extended. The other three are sign-extended. A fifth format, a compact sign-extended branch immediate, is reached through the third bit of the select. A parameter can remove it. The opcode decoder that produces the format code sits outside the unit. So does any scaling of branch offsets.

Top module: `imm_extend_unit`

## Requirements
- R1: With select 3'b000 (immediate arithmetic), the output equals instruction bits 21:10 (12 bits), zero-extended to 64 bits.
- R2: With select 3'b001 (data transfer), the output equals instruction bits 20:12 (9 bits), sign-extended from bit 20. For example, a field holding -18 gives 64'hFFFF_FFFF_FFFF_FFEE.
- R3: With select 3'b010 (unconditional branch), the output equals instruction bits 25:0 (26 bits), sign-extended from bit 25.
- R4: With select 3'b011 (compare-and-branch), the output equals instruction bits 23:5 (19 bits), sign-extended from bit 23.
- R5: With select 3'b100 (compact branch, enabled by default), the output equals instruction bits 15:5 (11 bits), sign-extended from bit 15.
- R6: The select codes 3'b101, 3'b110 and 3'b111 drive an all-zero output, whatever the instruction word holds.
- R7: Instruction bits outside the field of the selected format have no effect on the output.
- R8: The output depends only on the present inputs. There is no clocked state, so a new input pair yields its result with zero cycles of latency. All-zero inputs give an all-zero output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word holding the immediate field |
| fmt_sel | input | 3 | Format code: 000 I, 001 D, 010 B, 011 CB, 100 compact branch |
| imm_out | output | 64 | Extended 64-bit constant |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the ports. The driver applies a new instruction and format code just after a rising edge and queues the expected constant at the same moment. The monitor compares the output half a period later, on the falling edge, when the combinational path has settled. Each queued item is therefore checked exactly once, before the next stimulus replaces it.

// File: rtl/imm_ext_pkg.sv
package imm_ext_pkg;

    localparam int INSN_W  = 32;
    localparam int DATA_W  = 64;
    localparam int SEL_W   = 3;
    localparam int MAX_FMT = 5;

    typedef enum logic [SEL_W-1:0] {
        FMT_ARITH   = 3'b000,
        FMT_XFER    = 3'b001,
        FMT_BRANCH  = 3'b010,
        FMT_CMPBR   = 3'b011,
        FMT_SHORTBR = 3'b100
    } fmt_e;

    typedef struct packed {
        logic [4:0] lsb;
        logic [5:0] width;
        logic       sext;
    } field_desc_t;

    // Field layout for each format, indexed by its select code
    function automatic field_desc_t fmt_desc(input int unsigned idx);
        field_desc_t d;
        case (idx)
            0:       d = '{lsb: 5'd10, width: 6'd12, sext: 1'b0};
            1:       d = '{lsb: 5'd12, width: 6'd9,  sext: 1'b1};
            2:       d = '{lsb: 5'd0,  width: 6'd26, sext: 1'b1};
            3:       d = '{lsb: 5'd5,  width: 6'd19, sext: 1'b1};
            default: d = '{lsb: 5'd5,  width: 6'd11, sext: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/imm_field_extract.sv
module imm_field_extract #(
    parameter int INSN_W   = 32,
    parameter int DATA_W   = 64,
    parameter int LSB      = 0,
    parameter int WIDTH    = 12,
    parameter bit SIGN_EXT = 1'b1
) (
    input  logic [INSN_W-1:0] insn,
    output logic [DATA_W-1:0] value
);
    localparam int PAD_W = DATA_W - WIDTH;

    logic [WIDTH-1:0] field;
    assign field = insn[LSB +: WIDTH];

    generate
        if (SIGN_EXT) begin : g_signed
            assign value = {{PAD_W{field[WIDTH-1]}}, field};
        end else begin : g_unsigned
            assign value = {{PAD_W{1'b0}}, field};
        end
    endgenerate
endmodule

// File: rtl/imm_format_mux.sv
module imm_format_mux #(
    parameter int NUM_IN = 5,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic [NUM_IN-1:0][DATA_W-1:0] cand,
    input  logic [SEL_W-1:0]              sel,
    output logic [DATA_W-1:0]             out
);
    always_comb begin
        out = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            if (sel == SEL_W'(k)) out = cand[k];
        end
    end
endmodule

// File: rtl/imm_extend_unit.sv
module imm_extend_unit
    import imm_ext_pkg::*;
#(
    parameter bit ENABLE_I2 = 1'b1
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [SEL_W-1:0]  fmt_sel,
    output logic [DATA_W-1:0] imm_out
);
    localparam int NUM_FMT = ENABLE_I2 ? MAX_FMT : MAX_FMT - 1;

    logic [NUM_FMT-1:0][DATA_W-1:0] cand;

    generate
        for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
            localparam field_desc_t D = fmt_desc(g);
            imm_field_extract #(
                .INSN_W  (INSN_W),
                .DATA_W  (DATA_W),
                .LSB     (int'(D.lsb)),
                .WIDTH   (int'(D.width)),
                .SIGN_EXT(D.sext)
            ) u_extract (
                .insn (insn),
                .value(cand[g])
            );
        end
    endgenerate

    imm_format_mux #(
        .NUM_IN(NUM_FMT),
        .SEL_W (SEL_W),
        .DATA_W(DATA_W)
    ) u_mux (
        .cand(cand),
        .sel (fmt_sel),
        .out (imm_out)
    );
endmodule

// File: rtl/imm_extend_chk.sv
module imm_extend_chk
    import imm_ext_pkg::*;
#(
    parameter bit ENABLE_I2 = 1'b1
) (
    input logic [INSN_W-1:0] insn,
    input logic [SEL_W-1:0]  fmt_sel,
    input logic [DATA_W-1:0] imm_out
);
    always_comb begin
        if (fmt_sel == 3'b000) begin
            // R1
            arith_zero_chk: assert (imm_out == {52'd0, insn[21:10]});
        end
        if (fmt_sel == 3'b001) begin
            // R2
            xfer_sext_chk: assert (imm_out == {{55{insn[20]}}, insn[20:12]});
        end
        if (fmt_sel == 3'b010) begin
            // R3
            branch_sext_chk: assert (imm_out == {{38{insn[25]}}, insn[25:0]});
        end
        if (fmt_sel == 3'b011) begin
            // R4
            cmpbr_sext_chk: assert (imm_out == {{45{insn[23]}}, insn[23:5]});
        end
        if (ENABLE_I2 && fmt_sel == 3'b100) begin
            // R5
            shortbr_sext_chk: assert (imm_out == {{53{insn[15]}}, insn[15:5]});
        end
        if (fmt_sel > 3'b100) begin
            // R6
            undef_zero_chk: assert (imm_out == '0);
        end
    end
endmodule

bind imm_extend_unit imm_extend_chk #(.ENABLE_I2(ENABLE_I2)) u_chk (
    .insn   (insn),
    .fmt_sel(fmt_sel),
    .imm_out(imm_out)
);

// File: tb/imm_extend_unit_bench.sv
`timescale 1ns/1ps
module imm_extend_unit_bench;

    typedef struct {
        logic [31:0] insn;
        logic [2:0]  sel;
        logic [63:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = '0;
    logic [2:0]  fmt_sel = '0;
    logic [63:0] imm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    imm_extend_unit u_imm_extend_unit (
        .insn   (insn),
        .fmt_sel(fmt_sel),
        .imm_out(imm_out)
    );

    function automatic void layout(input logic [2:0] s, output int lsb,
                                   output int wid, output bit sx);
        case (s)
            3'd0: begin lsb = 10; wid = 12; sx = 0; end
            3'd1: begin lsb = 12; wid = 9;  sx = 1; end
            3'd2: begin lsb = 0;  wid = 26; sx = 1; end
            3'd3: begin lsb = 5;  wid = 19; sx = 1; end
            3'd4: begin lsb = 5;  wid = 11; sx = 1; end
            default: begin lsb = 0; wid = 0; sx = 0; end
        endcase
    endfunction

    // Reference model written as integer arithmetic from the requirements
    function automatic logic [63:0] model(input logic [31:0] w, input logic [2:0] s);
        int lsb, wid; bit sx; longint f, span;
        layout(s, lsb, wid, sx);
        if (wid == 0) return 64'd0;
        span = longint'(1) << wid;
        f = longint'(w >> lsb) & (span - 1);
        if (sx && f >= span / 2) f = f - span;
        return 64'(f);
    endfunction

    function automatic logic [31:0] field_mask(input logic [2:0] s);
        int lsb, wid; bit sx;
        layout(s, lsb, wid, sx);
        if (wid == 0) return 32'd0;
        return 32'(((longint'(1) << wid) - 1) << lsb);
    endfunction

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(input logic [31:0] w, input logic [2:0] s,
                         input logic [63:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #0.5;
        insn    = w;
        fmt_sel = s;
        it.insn = w; it.sel = s; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (imm_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s insn=%h sel=%0d actual=%h expected=%h",
                         it.tag, it.insn, it.sel, imm_out, it.exp);
            end
        end
    end

    initial begin
        logic [31:0] m;
        int lsb, wid; bit sx;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R8: all-zero inputs give zero, same-cycle result
        drive(32'h0, 3'd0, 64'd0, "R8");

        // R2: negative data-transfer offset -18 (9-bit field 0x1EE)
        drive(32'h1EE << 12, 3'd1, 64'hFFFF_FFFF_FFFF_FFEE, "R2");

        for (int s = 0; s < 5; s++) begin
            logic [2:0] sc;
            sc = 3'(s);
            m = field_mask(sc);
            layout(sc, lsb, wid, sx);
            // all-ones field
            drive(m, sc, model(m, sc), req_of(sc));
            // sign bit only
            drive(32'(1) << (lsb + wid - 1), sc,
                  model(32'(1) << (lsb + wid - 1), sc), req_of(sc));
            // largest positive value, every other bit set
            drive(~(32'(1) << (lsb + wid - 1)), sc,
                  model(~(32'(1) << (lsb + wid - 1)), sc), req_of(sc));
            // R7: bits outside the field set, field zero
            drive(~m, sc, 64'd0, "R7");
            // R7: field pattern with outside noise
            drive((32'h5A5A_A5A5 & m) | (32'hC33C_3CC3 & ~m), sc,
                  model(32'h5A5A_A5A5 & m, sc), "R7");
        end

        // R6: undefined codes give zero
        for (int s = 5; s < 8; s++) begin
            drive(32'hFFFF_FFFF, 3'(s), 64'd0, "R6");
            drive(32'h8765_4321, 3'(s), 64'd0, "R6");
        end

        // R8: back-to-back changes, one result per cycle
        drive(32'h0000_0400, 3'd0, 64'd1, "R8");
        drive(32'h0000_0020, 3'd3, 64'd1, "R8");
        drive(32'h0200_0000, 3'd2, 64'hFFFF_FFFF_FE00_0000, "R8");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule